// File: doc/BRIEF.md
# Flash Command and Lock-Protection Sequencer

This block sits in front of an embedded flash array. Software writes a command word to it. The word holds an access key, a command code and a page number. The sequencer checks the key and refuses anything that is malformed or arrives while it is busy. It then checks the command against the protection state. Allowed commands are either carried out on the protection registers in one cycle, or handed to the flash array through a start/busy/done handshake.

The protection state has three parts:
- per-region lock bits, where each region covers 64 pages;
- a one-way security bit, which blocks the debug access path while it is set;
- two general-purpose non-volatile bits.

An external erase input clears the lock bits and the general-purpose bits once it has been held for a programmable number of cycles. That event also arms the release of the security bit. The next full erase that completes then clears it. Four sticky status flags and an interrupt report the outcome of each command.

The flash array itself is a behavioural model. It keeps one programmed/blank bit per page and takes a fixed number of cycles per operation. The sequencer is a three-state machine:
- ST_IDLE: ready. A valid keyed write moves it to ST_CHECK.
- ST_CHECK: a single cycle. It returns to ST_IDLE after a lock abort or a protection-register command. It moves to ST_RUN after starting an array operation.
- ST_RUN: waits for the array. It returns to ST_IDLE on array done.

Top module: `flash_cmd_seq`

## Requirements
- R1: The command word carries the key in bits 31:24, the page number in bits 17:8 and the command code in bits 3:0. A write whose key byte differs from the KEY parameter sets key_err at the following edge, starts nothing and leaves ready high.
- R2: Command codes are 1 page program, 2 page erase, 3 lock region, 4 unlock region, 5 full erase, 6 set security, 7 set general bit, 8 clear general bit. Codes 3, 4, 6, 7 and 8 keep ready low for one cycle after the write edge. Codes 1 and 2 keep it low for PAGE_LAT+1 cycles, and code 5 for FULL_LAT+1 cycles. done_flag is set at the edge where ready returns high.
- R3: A write with the correct key sets cmd_err and is otherwise ignored in either of two cases: it arrives while ready is low, or its code is 0 or above 8.
- R4: A page program or page erase aimed at a page whose region is locked is aborted after one cycle. The abort sets lock_err and done_flag and leaves the page unchanged.
- R5: A full erase issued while any lock bit is set is aborted after one cycle with lock_err, and no page changes.
- R6: Code 3 sets and code 4 clears lock bit page/64 of lock_bits.
- R7: Code 6 sets secure. While secure is high, dbg_grant stays low whatever dbg_req does. No command clears secure.
- R8: Holding erase_pin high for ERASE_MIN consecutive cycles clears all lock bits and both general bits at the ERASE_MIN-th edge. A shorter pulse has no effect.
- R9: secure clears only at the completion of a full erase that follows a qualified erase_pin event. A full erase without such an event leaves secure set.
- R10: Code 7 sets and code 8 clears gpnvm bit (page bit 0).
- R11: A stat_rd pulse clears done_flag, lock_err, key_err and cmd_err at that edge, unless the same edge sets one of them.
- R12: irq is high exactly when done_flag or lock_err is high.
- R13: A completed page program makes rd_blank low for that page. A page erase makes it high again. A full erase makes every page blank.
- R14: After reset, ready is high, all flags are low, lock bits, secure and gpnvm are zero, and every page reads blank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word: key, page, code |
| stat_rd | input | 1 | Status read strobe, clears the sticky flags |
| erase_pin | input | 1 | External erase request, level |
| dbg_req | input | 1 | Debug access request |
| rd_page | input | 10 | Page queried on rd_blank |
| ready | output | 1 | High when no command is in progress |
| done_flag | output | 1 | Sticky: a command finished |
| lock_err | output | 1 | Sticky: a command was refused by a lock |
| key_err | output | 1 | Sticky: a write carried a wrong key |
| cmd_err | output | 1 | Sticky: write while busy or undefined code |
| irq | output | 1 | Interrupt request |
| lock_bits | output | 16 | Per-region lock bits |
| secure | output | 1 | Security bit |
| gpnvm | output | 2 | General-purpose non-volatile bits |
| dbg_grant | output | 1 | Debug access granted |
| rd_blank | output | 1 | Queried page is erased |

## Verification
Most internal faults appear at the ports within one cycle:
- a wrong protection bit shows directly on lock_bits, secure or gpnvm;
- a wrong machine state shows on ready, or as a cmd_err on the next write;
- a mis-decoded region shows as a lock_err, or as a missing one, one cycle after the write.

Faults inside the array model stay hidden until its done edge, PAGE_LAT or FULL_LAT cycles later. They then show as a late or early ready, or as a wrong rd_blank for the affected page. The bench keeps a per-cycle model of every output and compares each of them at every clock. A fault is therefore caught in the first cycle its effect reaches a port.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    typedef enum logic [3:0] {
        OP_NONE   = 4'd0,
        OP_PROG   = 4'd1,
        OP_PERASE = 4'd2,
        OP_LOCK   = 4'd3,
        OP_UNLOCK = 4'd4,
        OP_FERASE = 4'd5,
        OP_SECURE = 4'd6,
        OP_GPSET  = 4'd7,
        OP_GPCLR  = 4'd8
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_RUN
    } seq_state_e;

    typedef enum logic [1:0] {
        ARR_PROG,
        ARR_PERASE,
        ARR_FERASE
    } arr_op_e;

    function automatic logic op_defined(input logic [3:0] code);
        return (code >= 4'd1) && (code <= 4'd8);
    endfunction

    function automatic logic op_is_array(input op_e op);
        return (op == OP_PROG) || (op == OP_PERASE) || (op == OP_FERASE);
    endfunction

endpackage

// File: rtl/fcs_erase_qual.sv
module fcs_erase_qual #(
    parameter int MIN_CYC = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic erase_pin,
    output logic erase_hit
);
    localparam int CW = $clog2(MIN_CYC + 1);

    logic [CW-1:0] hold_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_cnt <= '0;
        end else if (!erase_pin) begin
            hold_cnt <= '0;
        end else if (hold_cnt != CW'(MIN_CYC)) begin
            hold_cnt <= hold_cnt + 1'b1;
        end
    end

    // One pulse at the edge where the pin has been high MIN_CYC cycles
    assign erase_hit = erase_pin && (hold_cnt == CW'(MIN_CYC - 1));

    AST_QUAL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        erase_hit |=> !erase_hit); // R8

endmodule

// File: rtl/fcs_protect.sv
module fcs_protect
    import fcs_pkg::*;
#(
    parameter int REG_W = 4,
    parameter int NREG  = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            erase_hit,
    input  logic            nvm_we,
    input  op_e             nvm_op,
    input  logic [REG_W-1:0] region,
    input  logic            gp_sel,
    input  logic            full_done,
    output logic [NREG-1:0] lock_bits,
    output logic [1:0]      gpnvm,
    output logic            secure
);
    logic armed;

    for (genvar i = 0; i < NREG; i++) begin : g_lock
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lock_bits[i] <= 1'b0;
            end else if (erase_hit) begin
                lock_bits[i] <= 1'b0;
            end else if (nvm_we && (region == REG_W'(i))) begin
                if (nvm_op == OP_LOCK)
                    lock_bits[i] <= 1'b1;
                else if (nvm_op == OP_UNLOCK)
                    lock_bits[i] <= 1'b0;
            end
        end
    end

    for (genvar g = 0; g < 2; g++) begin : g_gp
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                gpnvm[g] <= 1'b0;
            end else if (erase_hit) begin
                gpnvm[g] <= 1'b0;
            end else if (nvm_we && (gp_sel == 1'(g))) begin
                if (nvm_op == OP_GPSET)
                    gpnvm[g] <= 1'b1;
                else if (nvm_op == OP_GPCLR)
                    gpnvm[g] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            secure <= 1'b0;
            armed  <= 1'b0;
        end else begin
            if (full_done && armed)
                secure <= 1'b0;
            else if (nvm_we && (nvm_op == OP_SECURE))
                secure <= 1'b1;
            if (erase_hit)
                armed <= 1'b1;
            else if (full_done)
                armed <= 1'b0;
        end
    end

    AST_ERASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        erase_hit |=> (lock_bits == '0) && (gpnvm == 2'b00)); // R8

    AST_SECURE_ONEWAY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(secure) |-> $past(full_done)); // R9

endmodule

// File: rtl/fcs_array_model.sv
module fcs_array_model
    import fcs_pkg::*;
#(
    parameter int NUM_PAGES = 1024,
    parameter int PAGE_W    = 10,
    parameter int PAGE_LAT  = 12,
    parameter int FULL_LAT  = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  arr_op_e           op,
    input  logic [PAGE_W-1:0] page,
    input  logic [PAGE_W-1:0] rd_page,
    output logic              busy,
    output logic              done,
    output logic              rd_blank
);
    localparam int MAXLAT = (FULL_LAT > PAGE_LAT) ? FULL_LAT : PAGE_LAT;
    localparam int CNT_W  = $clog2(MAXLAT + 1);

    logic [CNT_W-1:0]     left_q;
    arr_op_e              op_q;
    logic [PAGE_W-1:0]    page_q;
    logic [NUM_PAGES-1:0] written_q;

    assign busy = (left_q != '0);
    assign done = (left_q == CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
            op_q   <= ARR_PROG;
            page_q <= '0;
        end else if (start) begin
            left_q <= (op == ARR_FERASE) ? CNT_W'(FULL_LAT) : CNT_W'(PAGE_LAT);
            op_q   <= op;
            page_q <= page;
        end else if (busy) begin
            left_q <= left_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            written_q <= '0;
        end else if (done) begin
            unique case (op_q)
                ARR_PROG:   written_q[page_q] <= 1'b1;
                ARR_PERASE: written_q[page_q] <= 1'b0;
                ARR_FERASE: written_q         <= '0;
                default:    written_q         <= written_q;
            endcase
        end
    end

    assign rd_blank = !written_q[rd_page];

    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy); // R2

endmodule

// File: rtl/fcs_seq.sv
module fcs_seq
    import fcs_pkg::*;
#(
    parameter logic [7:0] KEY   = 8'hA5,
    parameter int         PAGE_W = 10,
    parameter int         PPR_W  = 6,
    parameter int         NREG   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [31:0]       cmd_wdata,
    input  logic              stat_rd,
    input  logic [NREG-1:0]   lock_bits,
    input  logic              arr_busy,
    input  logic              arr_done,
    output logic              ready,
    output logic              done_flag,
    output logic              lock_err,
    output logic              key_err,
    output logic              cmd_err,
    output logic              nvm_we,
    output op_e               nvm_op,
    output logic [PAGE_W-1:0] cur_page,
    output logic              arr_start,
    output arr_op_e           arr_op,
    output logic              full_done
);
    localparam int REG_W = PAGE_W - PPR_W;

    seq_state_e state_q, state_d;
    op_e        op_q;
    logic [PAGE_W-1:0] page_q;

    logic             key_ok, code_ok, accept, locked, abort, finish;
    logic [3:0]       w_code;
    logic [PAGE_W-1:0] w_page;
    logic [REG_W-1:0]  region_q;
    logic             unused_fields;

    assign key_ok   = (cmd_wdata[31:24] == KEY);
    assign w_code   = cmd_wdata[3:0];
    assign w_page   = cmd_wdata[PAGE_W+7:8];
    assign code_ok  = op_defined(w_code);
    assign accept   = cmd_wr && key_ok && code_ok && (state_q == ST_IDLE);
    assign region_q = page_q[PAGE_W-1:PPR_W];
    assign unused_fields = ^{cmd_wdata[23:PAGE_W+8], cmd_wdata[7:4]};

    always_comb begin
        locked = 1'b0;
        if ((op_q == OP_PROG) || (op_q == OP_PERASE))
            locked = lock_bits[region_q];
        else if (op_q == OP_FERASE)
            locked = |lock_bits;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_NONE;
            page_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                op_q   <= op_e'(w_code);
                page_q <= w_page;
            end
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_CHECK;
            ST_CHECK: state_d = arr_start ? ST_RUN : ST_IDLE;
            ST_RUN:   if (arr_done) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        ready     = (state_q == ST_IDLE);
        arr_start = 1'b0;
        nvm_we    = 1'b0;
        abort     = 1'b0;
        full_done = 1'b0;
        arr_op    = ARR_PROG;
        unique case (state_q)
            ST_IDLE: ;
            ST_CHECK: begin
                abort     = locked;
                arr_start = op_is_array(op_q) && !locked;
                nvm_we    = !op_is_array(op_q);
            end
            ST_RUN:  full_done = arr_done && (op_q == OP_FERASE);
            default: ;
        endcase
        unique case (op_q)
            OP_PERASE: arr_op = ARR_PERASE;
            OP_FERASE: arr_op = ARR_FERASE;
            default:   arr_op = ARR_PROG;
        endcase
    end

    assign finish   = nvm_we || abort || ((state_q == ST_RUN) && arr_done);
    assign nvm_op   = op_q;
    assign cur_page = page_q;

    // Sticky status flags: a set wins over a read clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_flag <= 1'b0;
            lock_err  <= 1'b0;
            key_err   <= 1'b0;
            cmd_err   <= 1'b0;
        end else begin
            if (finish)       done_flag <= 1'b1;
            else if (stat_rd) done_flag <= 1'b0;
            if (abort)        lock_err <= 1'b1;
            else if (stat_rd) lock_err <= 1'b0;
            if (cmd_wr && !key_ok) key_err <= 1'b1;
            else if (stat_rd)      key_err <= 1'b0;
            if (cmd_wr && key_ok && (!code_ok || (state_q != ST_IDLE))) cmd_err <= 1'b1;
            else if (stat_rd) cmd_err <= 1'b0;
        end
    end

    AST_RUN_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> arr_busy); // R2

    AST_BAD_KEY_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !key_ok && ready) |=> ready); // R1

    AST_ABORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> ready && lock_err); // R4

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import fcs_pkg::*;
#(
    parameter int         NUM_PAGES        = 1024,
    parameter int         PAGES_PER_REGION = 64,
    parameter logic [7:0] KEY              = 8'hA5,
    parameter int         ERASE_MIN        = 40,
    parameter int         PAGE_LAT         = 12,
    parameter int         FULL_LAT         = 30,
    localparam int        PAGE_W           = $clog2(NUM_PAGES),
    localparam int        PPR_W            = $clog2(PAGES_PER_REGION),
    localparam int        REG_W            = PAGE_W - PPR_W,
    localparam int        NREG             = 1 << REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [31:0]       cmd_wdata,
    input  logic              stat_rd,
    input  logic              erase_pin,
    input  logic              dbg_req,
    input  logic [PAGE_W-1:0] rd_page,
    output logic              ready,
    output logic              done_flag,
    output logic              lock_err,
    output logic              key_err,
    output logic              cmd_err,
    output logic              irq,
    output logic [NREG-1:0]   lock_bits,
    output logic              secure,
    output logic [1:0]        gpnvm,
    output logic              dbg_grant,
    output logic              rd_blank
);
    logic              erase_hit, nvm_we, arr_start, arr_busy, arr_done, full_done;
    op_e               nvm_op;
    arr_op_e           arr_op;
    logic [PAGE_W-1:0] cur_page;

    fcs_erase_qual #(.MIN_CYC(ERASE_MIN)) u_qual (
        .clk(clk), .rst_n(rst_n), .erase_pin(erase_pin), .erase_hit(erase_hit)
    );

    fcs_seq #(.KEY(KEY), .PAGE_W(PAGE_W), .PPR_W(PPR_W), .NREG(NREG)) u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .stat_rd(stat_rd), .lock_bits(lock_bits), .arr_busy(arr_busy),
        .arr_done(arr_done), .ready(ready), .done_flag(done_flag),
        .lock_err(lock_err), .key_err(key_err), .cmd_err(cmd_err),
        .nvm_we(nvm_we), .nvm_op(nvm_op), .cur_page(cur_page),
        .arr_start(arr_start), .arr_op(arr_op), .full_done(full_done)
    );

    fcs_protect #(.REG_W(REG_W), .NREG(NREG)) u_prot (
        .clk(clk), .rst_n(rst_n), .erase_hit(erase_hit), .nvm_we(nvm_we),
        .nvm_op(nvm_op), .region(cur_page[PAGE_W-1:PPR_W]), .gp_sel(cur_page[0]),
        .full_done(full_done), .lock_bits(lock_bits), .gpnvm(gpnvm), .secure(secure)
    );

    fcs_array_model #(.NUM_PAGES(NUM_PAGES), .PAGE_W(PAGE_W),
                      .PAGE_LAT(PAGE_LAT), .FULL_LAT(FULL_LAT)) u_arr (
        .clk(clk), .rst_n(rst_n), .start(arr_start), .op(arr_op), .page(cur_page),
        .rd_page(rd_page), .busy(arr_busy), .done(arr_done), .rd_blank(rd_blank)
    );

    assign irq       = done_flag || lock_err;
    assign dbg_grant = dbg_req && !secure;

    AST_FULL_ERASE_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_start && (arr_op == ARR_FERASE)) |-> (lock_bits == '0)); // R5

    AST_SECURE_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(secure) |-> $past(nvm_we && (nvm_op == OP_SECURE))); // R7

endmodule

// File: tb/tb_flash_cmd_seq.sv
`timescale 1ns/1ps
module tb_flash_cmd_seq;
    localparam int         NP   = 1024;
    localparam int         PPR  = 64;
    localparam logic [7:0] KEY  = 8'hA5;
    localparam int         EMIN = 40;
    localparam int         PLAT = 12;
    localparam int         FLAT = 30;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0, stat_rd = 1'b0, erase_pin = 1'b0, dbg_req = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic [9:0]  rd_page = '0;
    logic        ready, done_flag, lock_err, key_err, cmd_err, irq, secure, dbg_grant, rd_blank;
    logic [15:0] lock_bits;
    logic [1:0]  gpnvm;

    flash_cmd_seq #(.NUM_PAGES(NP), .PAGES_PER_REGION(PPR), .KEY(KEY),
                    .ERASE_MIN(EMIN), .PAGE_LAT(PLAT), .FULL_LAT(FLAT)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .stat_rd(stat_rd), .erase_pin(erase_pin), .dbg_req(dbg_req),
        .rd_page(rd_page), .ready(ready), .done_flag(done_flag),
        .lock_err(lock_err), .key_err(key_err), .cmd_err(cmd_err), .irq(irq),
        .lock_bits(lock_bits), .secure(secure), .gpnvm(gpnvm),
        .dbg_grant(dbg_grant), .rd_blank(rd_blank)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Behavioural reference model
    int         m_left, m_op, m_page, m_ecnt;
    bit         m_abort, m_done, m_lerr, m_kerr, m_cerr, m_sec, m_armed;
    bit [15:0]  m_lock;
    bit [1:0]   m_gp;
    bit [NP-1:0] m_prog;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_left = 0; m_op = 0; m_page = 0; m_ecnt = 0; m_abort = 0;
            m_done = 0; m_lerr = 0; m_kerr = 0; m_cerr = 0; m_sec = 0; m_armed = 0;
            m_lock = '0; m_gp = '0; m_prog = '0;
        end else begin
            bit busy0, hit;
            int code, pg;
            busy0 = (m_left > 0);
            hit = 0;
            if (erase_pin) begin
                if (m_ecnt < EMIN) begin
                    m_ecnt++;
                    if (m_ecnt == EMIN) hit = 1;
                end
            end else m_ecnt = 0;
            if (stat_rd) begin m_done = 0; m_lerr = 0; m_kerr = 0; m_cerr = 0; end
            if (m_left > 0) begin
                m_left--;
                if (m_left == 0) begin
                    m_done = 1;
                    if (m_abort) m_lerr = 1;
                    else case (m_op)
                        1: m_prog[m_page] = 1;
                        2: m_prog[m_page] = 0;
                        3: m_lock[m_page / PPR] = 1;
                        4: m_lock[m_page / PPR] = 0;
                        5: begin m_prog = '0; if (m_armed) begin m_sec = 0; m_armed = 0; end end
                        6: m_sec = 1;
                        7: m_gp[m_page % 2] = 1;
                        8: m_gp[m_page % 2] = 0;
                        default: ;
                    endcase
                end
            end
            if (cmd_wr) begin
                code = int'(cmd_wdata[3:0]);
                pg   = int'(cmd_wdata[17:8]);
                if (cmd_wdata[31:24] != KEY) m_kerr = 1;
                else if (busy0 || code == 0 || code > 8) m_cerr = 1;
                else begin
                    m_op = code; m_page = pg;
                    m_abort = ((code == 1 || code == 2) && m_lock[pg / PPR]) ||
                              (code == 5 && m_lock != 0);
                    if (m_abort) m_left = 1;
                    else if (code == 1 || code == 2) m_left = PLAT + 1;
                    else if (code == 5) m_left = FLAT + 1;
                    else m_left = 1;
                end
            end
            if (hit) begin m_lock = '0; m_gp = '0; m_armed = 1; end
        end
    end

    // Per-cycle comparison, away from the edge
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            chk("R2", "ready", ready, m_left == 0);
            chk("R2", "done_flag", done_flag, m_done);
            chk("R4", "lock_err", lock_err, m_lerr);
            chk("R1", "key_err", key_err, m_kerr);
            chk("R3", "cmd_err", cmd_err, m_cerr);
            chk("R12", "irq", irq, m_done | m_lerr);
            chk("R6", "lock_bits", lock_bits, m_lock);
            chk("R9", "secure", secure, m_sec);
            chk("R10", "gpnvm", gpnvm, m_gp);
            chk("R7", "dbg_grant", dbg_grant, dbg_req & !m_sec);
            chk("R13", "rd_blank", rd_blank, !m_prog[rd_page]);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] key, input logic [3:0] code, input int pg);
        @(negedge clk);
        cmd_wdata = {key, 6'd0, 10'(pg), 4'd0, code};
        cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic wait_idle;
        while (m_left > 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic rd_status;
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R14 reset state
        chk("R14", "reset ready", ready, 1);
        chk("R14", "reset locks", lock_bits, 0);
        chk("R14", "reset flags", {done_flag, lock_err, key_err, cmd_err, secure, gpnvm}, 0);
        chk("R14", "reset blank", rd_blank, 1);

        // R1 wrong key
        wr(8'h3C, 4'd1, 5);
        chk("R1", "bad key flag", key_err, 1);
        chk("R1", "bad key ready", ready, 1);
        rd_status();
        chk("R11", "flags after read", {done_flag, lock_err, key_err, cmd_err}, 0);

        // R13 program then erase a page
        wr(KEY, 4'd1, 5); wait_idle();
        rd_page = 10'd5; #1;
        chk("R13", "page5 programmed", rd_blank, 0);
        chk("R2", "done after program", done_flag, 1);

        // R6 lock region 0, R4 aborted erase
        wr(KEY, 4'd3, 10); wait_idle();
        chk("R6", "region0 locked", lock_bits[0], 1);
        wr(KEY, 4'd2, 5); wait_idle();
        chk("R4", "abort lock_err", lock_err, 1);
        chk("R4", "page5 kept", rd_blank, 0);
        rd_status();
        wr(KEY, 4'd1, 70); wait_idle();
        rd_page = 10'd70; #1;
        chk("R13", "page70 programmed", rd_blank, 0);

        // R5 full erase while locked
        rd_status();
        wr(KEY, 4'd5, 0); wait_idle();
        chk("R5", "full erase refused", lock_err, 1);
        chk("R5", "page70 kept", rd_blank, 0);

        // R3 write while busy, undefined code
        rd_status();
        wr(KEY, 4'd1, 300);
        wr(KEY, 4'd2, 300);
        chk("R3", "busy write", cmd_err, 1);
        wait_idle();
        rd_status();
        wr(KEY, 4'd12, 0);
        chk("R3", "undefined code", cmd_err, 1);
        chk("R3", "undefined ready", ready, 1);

        // R10 general bits
        wr(KEY, 4'd7, 1); wait_idle();
        wr(KEY, 4'd7, 0); wait_idle();
        wr(KEY, 4'd8, 1); wait_idle();
        chk("R10", "gpnvm", gpnvm, 2'b01);

        // R7 security blocks debug
        wr(KEY, 4'd6, 0); wait_idle();
        dbg_req = 1'b1; #1;
        chk("R7", "debug refused", dbg_grant, 0);

        // R9 full erase without erase pin keeps security
        wr(KEY, 4'd4, 10); wait_idle();
        wr(KEY, 4'd5, 0); wait_idle();
        chk("R9", "secure kept", secure, 1);
        chk("R13", "all blank", rd_blank, 1);

        // R8 short and long erase pulses
        wr(KEY, 4'd3, 200); wait_idle();
        @(negedge clk); erase_pin = 1'b1; cyc(EMIN - 5); erase_pin = 1'b0; cyc(2);
        chk("R8", "short pulse no effect", lock_bits[3], 1);
        chk("R8", "short pulse gp kept", gpnvm, 2'b01);
        erase_pin = 1'b1; cyc(EMIN + 3); erase_pin = 1'b0; cyc(2);
        chk("R8", "locks cleared", lock_bits, 0);
        chk("R8", "gp cleared", gpnvm, 0);
        chk("R9", "secure until full erase", secure, 1);

        // R9 full erase after qualified erase clears security
        wr(KEY, 4'd1, 900); wait_idle();
        wr(KEY, 4'd5, 0); wait_idle();
        chk("R9", "secure released", secure, 0);
        #1 chk("R7", "debug granted", dbg_grant, 1);
        chk("R12", "irq", irq, 1);
        rd_status();
        chk("R12", "irq low", irq, 0);
        cyc(4);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule